// File: doc/BRIEF.md
# Interrupt Message Redirection Unit

This block sits between the inbound write path from the I/O ports and the two processor buses. Each inbound write is decoded. A write that falls inside the interrupt message window becomes an interrupt. Any other write is an ordinary posted write: the block accepts it and counts it as outstanding until the downstream path reports that it has been flushed.

For an interrupt, the block picks a target from a bank of per-processor task-priority entries. It puts the target's destination ID into the message address and clears the redirection hint. It then holds the message in a one-entry buffer. The message leaves only when no earlier posted write is still outstanding and both bus channels are ready. It is then driven on both buses in the same cycle, so an interrupt can never overtake data written before it.

Software fills the task-priority entries through a simple register write port. The target is chosen at the moment an interrupt is accepted, using the entries as they stand in that cycle.

Top module: `intr_msg_redirect`

## Requirements
- R1: A write is an interrupt when `(addr & 0xFFF0_0000) == 0xFEE0_0000`. Any other accepted write is a posted write. A posted write raises the outstanding count and produces no bus message.
- R2: The winning entry is the valid entry with the lowest priority value. When several valid entries share that value, the lowest index wins.
- R3: When an entry wins, address bits 19:12 of the message carry one of its IDs. Incoming address bit 2 selects which: 0 selects the physical ID, 1 selects the logical ID. All other address bits are carried over, except bit 3.
- R4: When no entry is valid, address bits 19:12 pass through unchanged.
- R5: Address bit 3 (redirection hint) is 0 on every message issued.
- R6: A message is driven on bus 0 and bus 1 in the same cycle, with identical address and data. It is driven only in a cycle where both `bus0_rdy_i` and `bus1_rdy_i` are high.
- R7: A held interrupt is not issued while the outstanding count is nonzero. Each accepted posted write adds 1 to the count. Each `pw_done_i` cycle subtracts 1. A `pw_done_i` while the count is 0 is ignored.
- R8: Each accepted interrupt produces exactly one message per bus, and no two interrupts are ever merged. With the count at 0 and both buses ready, the request appears in the cycle after acceptance and drops in the following cycle.
- R9: After reset, both requests are low, `in_ready_o` is high, the outstanding count is 0 and every entry is invalid.
- R10: A write through the entry port sets the entry `tpr_idx_i` to `tpr_wdata_i`. The fields of `tpr_wdata_i` are: bit 20 valid, bits 19:16 priority, bits 15:8 physical ID, bits 7:0 logical ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Inbound write valid |
| in_ready_o | output | 1 | Inbound write accepted when high with valid |
| in_addr_i | input | 32 | Inbound write address |
| in_data_i | input | 32 | Inbound write data |
| pw_done_i | input | 1 | One earlier posted write has been flushed |
| tpr_we_i | input | 1 | Task-priority entry write enable |
| tpr_idx_i | input | 3 | Entry index to write |
| tpr_wdata_i | input | 21 | Entry value {valid, prio[3:0], phys_id[7:0], log_id[7:0]} |
| bus0_req_o | output | 1 | Message request, bus 0 |
| bus0_addr_o | output | 32 | Message address, bus 0 |
| bus0_data_o | output | 32 | Message data, bus 0 |
| bus0_rdy_i | input | 1 | Bus 0 can take a message |
| bus1_req_o | output | 1 | Message request, bus 1 |
| bus1_addr_o | output | 32 | Message address, bus 1 |
| bus1_data_o | output | 32 | Message data, bus 1 |
| bus1_rdy_i | input | 1 | Bus 1 can take a message |

## Verification
On every cycle, the assertions check four things:
- no request goes out while posted writes are still outstanding;
- the hint bit is clear on every issued address;
- a request lasts a single cycle;
- the outstanding count does not go below zero.

They also check that the winner is never beaten by another valid entry, either on priority or, at equal priority, on index.

Only the directed scenarios can show the rest:
- the exact ID placed in bits 19:12, for both ID types and for the no-valid case;
- that a write outside the window produces no message;
- the release point after the last flush;
- that back-to-back interrupts come out as separate messages.

// File: rtl/intr_redir_pkg.sv
package intr_redir_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned PRIO_W   = 4;
  localparam int unsigned ID_W     = 8;
  localparam int unsigned ID_LSB   = 12;
  localparam int unsigned HINT_BIT = 3;
  localparam int unsigned DM_BIT   = 2;
  localparam int unsigned N_BUS    = 2;

  typedef struct packed {
    logic              vld;
    logic [PRIO_W-1:0] prio;
    logic [ID_W-1:0]   phys_id;
    logic [ID_W-1:0]   log_id;
  } tpr_ent_t;

  localparam int unsigned ENT_W = $bits(tpr_ent_t);
endpackage

// File: rtl/tpr_bank.sv
module tpr_bank
  import intr_redir_pkg::*;
#(
  parameter int unsigned N_ENT = 8,
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  tpr_ent_t             wdata_i,
  output tpr_ent_t [N_ENT-1:0] ent_o
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                ent_o[g] <= '0;
      else if (we_i && idx_i == IDX_W'(g))        ent_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/tpr_arbiter.sv
module tpr_arbiter
  import intr_redir_pkg::*;
#(
  parameter int unsigned N_ENT = 8,
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  tpr_ent_t [N_ENT-1:0] ent_i,
  output logic                 win_vld_o,
  output logic [IDX_W-1:0]     win_idx_o,
  output tpr_ent_t             win_ent_o
);
  // strict compare while scanning upward: ties keep the lower index
  always_comb begin
    win_vld_o = 1'b0;
    win_idx_o = '0;
    win_ent_o = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (ent_i[i].vld && (!win_vld_o || ent_i[i].prio < win_ent_o.prio)) begin
        win_vld_o = 1'b1;
        win_idx_o = IDX_W'(i);
        win_ent_o = ent_i[i];
      end
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_chk
    // R2
    arb_best_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ent_i[g].vld |-> (win_vld_o && win_ent_o.prio <= ent_i[g].prio));
    // R2
    arb_tie_low_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ent_i[g].vld && ent_i[g].prio == win_ent_o.prio) |-> (win_idx_o <= IDX_W'(g)));
  end
endmodule

// File: rtl/posted_cnt.sv
module posted_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic zero_o,
  output logic full_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
  assign full_o = (cnt_q == CNT_MAX);

  // R7
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && dec_i && !inc_i) |=> (cnt_q == '0));
endmodule

// File: rtl/intr_msg_redirect.sv
module intr_msg_redirect
  import intr_redir_pkg::*;
#(
  parameter int unsigned          N_ENT    = 8,
  parameter int unsigned          CNT_W    = 4,
  parameter logic [ADDR_W-1:0]    WIN_BASE = 32'hFEE0_0000,
  parameter logic [ADDR_W-1:0]    WIN_MASK = 32'hFFF0_0000,
  localparam int unsigned         IDX_W    = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              pw_done_i,
  input  logic              tpr_we_i,
  input  logic [IDX_W-1:0]  tpr_idx_i,
  input  logic [ENT_W-1:0]  tpr_wdata_i,
  output logic              bus0_req_o,
  output logic [ADDR_W-1:0] bus0_addr_o,
  output logic [DATA_W-1:0] bus0_data_o,
  input  logic              bus0_rdy_i,
  output logic              bus1_req_o,
  output logic [ADDR_W-1:0] bus1_addr_o,
  output logic [DATA_W-1:0] bus1_data_o,
  input  logic              bus1_rdy_i
);
  tpr_ent_t [N_ENT-1:0] tpr_q;
  tpr_ent_t             win_ent;
  logic                 win_vld;
  logic [IDX_W-1:0]     win_idx;
  logic                 cnt_zero, cnt_full;
  logic                 is_irq, acc, fire;
  logic [ADDR_W-1:0]    msg_addr, hold_addr_q;
  logic [DATA_W-1:0]    hold_data_q;
  logic                 hold_q;
  logic [N_BUS-1:0]     bus_rdy, bus_req;
  logic [ADDR_W-1:0]    bus_addr [N_BUS];
  logic [DATA_W-1:0]    bus_data [N_BUS];

  tpr_bank #(.N_ENT(N_ENT)) u_bank (
    .clk_i, .rst_ni,
    .we_i(tpr_we_i), .idx_i(tpr_idx_i), .wdata_i(tpr_ent_t'(tpr_wdata_i)),
    .ent_o(tpr_q)
  );

  tpr_arbiter #(.N_ENT(N_ENT)) u_arb (
    .clk_i, .rst_ni,
    .ent_i(tpr_q), .win_vld_o(win_vld), .win_idx_o(win_idx), .win_ent_o(win_ent)
  );

  assign is_irq     = (in_addr_i & WIN_MASK) == WIN_BASE;
  assign in_ready_o = !hold_q && !cnt_full;
  assign acc        = in_valid_i && in_ready_o;

  posted_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .inc_i(acc && !is_irq), .dec_i(pw_done_i),
    .zero_o(cnt_zero), .full_o(cnt_full)
  );

  always_comb begin
    msg_addr = in_addr_i;
    if (win_vld)
      msg_addr[ID_LSB +: ID_W] = in_addr_i[DM_BIT] ? win_ent.log_id : win_ent.phys_id;
    msg_addr[HINT_BIT] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= 1'b0;
      hold_addr_q <= '0;
      hold_data_q <= '0;
    end else if (acc && is_irq) begin
      hold_q      <= 1'b1;
      hold_addr_q <= msg_addr;
      hold_data_q <= in_data_i;
    end else if (fire) begin
      hold_q      <= 1'b0;
    end
  end

  assign bus_rdy = {bus1_rdy_i, bus0_rdy_i};
  // ordering gate: all earlier posted writes flushed, every bus ready
  assign fire    = hold_q && cnt_zero && (&bus_rdy);

  for (genvar b = 0; b < N_BUS; b++) begin : g_bus
    assign bus_req[b]  = fire;
    assign bus_addr[b] = hold_addr_q;
    assign bus_data[b] = hold_data_q;
  end

  assign bus0_req_o  = bus_req[0];
  assign bus0_addr_o = bus_addr[0];
  assign bus0_data_o = bus_data[0];
  assign bus1_req_o  = bus_req[1];
  assign bus1_addr_o = bus_addr[1];
  assign bus1_data_o = bus_data[1];

  // R7
  order_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus0_req_o |-> cnt_zero);
  // R5
  hint_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus0_req_o |-> !bus0_addr_o[HINT_BIT]);
  // R8
  one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus0_req_o |=> !bus0_req_o);
endmodule

// File: tb/intr_msg_redirect_bench.sv
module intr_msg_redirect_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [31:0] in_addr = '0, in_data = '0;
  logic        pw_done = 1'b0;
  logic        tpr_we = 1'b0;
  logic [2:0]  tpr_idx = '0;
  logic [20:0] tpr_wdata = '0;
  logic        req0, req1, rdy0 = 1'b1, rdy1 = 1'b1;
  logic [31:0] addr0, addr1, data0, data1;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  intr_msg_redirect u_intr_msg_redirect (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_addr_i(in_addr), .in_data_i(in_data),
    .pw_done_i(pw_done),
    .tpr_we_i(tpr_we), .tpr_idx_i(tpr_idx), .tpr_wdata_i(tpr_wdata),
    .bus0_req_o(req0), .bus0_addr_o(addr0), .bus0_data_o(data0), .bus0_rdy_i(rdy0),
    .bus1_req_o(req1), .bus1_addr_o(addr1), .bus1_data_o(data1), .bus1_rdy_i(rdy1)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_tpr(int idx, bit vld, logic [3:0] prio, logic [7:0] ph, logic [7:0] lg);
    @(negedge clk);
    tpr_we = 1'b1; tpr_idx = 3'(idx); tpr_wdata = {vld, prio, ph, lg};
    @(negedge clk);
    tpr_we = 1'b0;
  endtask

  task automatic clear_tprs();
    for (int i = 0; i < 8; i++) wr_tpr(i, 1'b0, 4'h0, 8'h0, 8'h0);
  endtask

  task automatic push(string req, logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    check(req, {31'b0, in_ready}, 32'd1);
    in_valid = 1'b1; in_addr = a; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); pw_done = 1'b1;
    @(negedge clk); pw_done = 1'b0;
  endtask

  // sampled at a negedge: message must be on both buses now, gone one cycle later
  task automatic expect_msg(string req, logic [31:0] a, logic [31:0] d);
    #1;
    check({req, " req0"}, {31'b0, req0}, 32'd1);
    check({req, " req1"}, {31'b0, req1}, 32'd1);
    check({req, " addr0"}, addr0, a);
    check({req, " addr1"}, addr1, a);
    check({req, " data0"}, data0, d);
    check({req, " data1"}, data1, d);
    @(negedge clk); #1;
    check({req, " one-shot"}, {31'b0, req0}, 32'd0);
  endtask

  task automatic expect_quiet(string req, int cycles);
    for (int i = 0; i < cycles; i++) begin
      #1;
      check(req, {30'b0, req1, req0}, 32'd0);
      @(negedge clk);
    end
    #1;
  endtask

  function automatic logic [31:0] exp_addr(logic [31:0] a, bit hit, logic [7:0] id);
    logic [31:0] r = a;
    if (hit) r[19:12] = id;
    r[3] = 1'b0;
    return r;
  endfunction

  task automatic t_reset();
    #1;
    check("R9 ready", {31'b0, in_ready}, 32'd1);
    check("R9 req", {30'b0, req1, req0}, 32'd0);
  endtask

  task automatic t_passthru();
    push("R4", 32'hFEE0_A00C, 32'h0000_0031);
    expect_msg("R4 R5 no valid entry", exp_addr(32'hFEE0_A00C, 0, 8'h0), 32'h31);
  endtask

  task automatic t_arb();
    wr_tpr(0, 1, 4'd9, 8'h11, 8'h81);
    wr_tpr(1, 1, 4'd4, 8'h22, 8'h82);
    wr_tpr(3, 1, 4'd2, 8'h33, 8'hB3);
    wr_tpr(6, 1, 4'd7, 8'h44, 8'h84);
    push("R2", 32'hFEE0_0008, 32'h41);
    expect_msg("R2 R3 R10 phys", 32'hFEE3_3000, 32'h41);
    push("R3", 32'hFEE0_0004, 32'h42);
    expect_msg("R3 logical", 32'hFEEB_3004, 32'h42);
  endtask

  task automatic t_tie();
    clear_tprs();
    wr_tpr(7, 1, 4'd8, 8'h77, 8'hF7);
    wr_tpr(5, 1, 4'd3, 8'h55, 8'hF5);
    wr_tpr(2, 1, 4'd3, 8'h25, 8'hF2);
    push("R2", 32'hFEE0_0000, 32'h51);
    expect_msg("R2 tie low index", 32'hFEE2_5000, 32'h51);
    wr_tpr(2, 0, 4'd3, 8'h25, 8'hF2);
    push("R2", 32'hFEE0_0000, 32'h52);
    expect_msg("R2 invalid entry skipped", 32'hFEE5_5000, 32'h52);
  endtask

  task automatic t_window();
    push("R1", 32'hFEC0_0010, 32'h61);
    expect_quiet("R1 posted write no message", 2);
    push("R1", 32'hFEE0_0000, 32'h62);
    expect_quiet("R1 R7 held behind posted write", 2);
    pulse_done();
    expect_msg("R1 R7 released", 32'hFEE5_5000, 32'h62);
  endtask

  task automatic t_order();
    push("R7", 32'h1000_0000, 32'h71);
    push("R7", 32'h1000_0004, 32'h72);
    push("R7", 32'hFEE0_0000, 32'h73);
    expect_quiet("R7 count 2", 3);
    pulse_done();
    expect_quiet("R7 count 1", 2);
    pulse_done();
    expect_msg("R7 count 0", 32'hFEE5_5000, 32'h73);
    pulse_done();
    pulse_done();
    push("R7", 32'h2000_0000, 32'h74);
    push("R7", 32'hFEE0_0000, 32'h75);
    expect_quiet("R7 done at zero ignored", 2);
    pulse_done();
    expect_msg("R7 release after floor", 32'hFEE5_5000, 32'h75);
  endtask

  task automatic t_ready();
    rdy1 = 1'b0;
    push("R6", 32'hFEE0_0000, 32'h81);
    expect_quiet("R6 bus1 busy", 3);
    rdy1 = 1'b1;
    expect_msg("R6 both ready", 32'hFEE5_5000, 32'h81);
    rdy0 = 1'b0;
    push("R6", 32'hFEE0_0000, 32'h82);
    expect_quiet("R6 bus0 busy", 2);
    rdy0 = 1'b1;
    expect_msg("R6 both ready again", 32'hFEE5_5000, 32'h82);
  endtask

  task automatic t_b2b();
    push("R8", 32'hFEE0_0000, 32'h91);
    expect_msg("R8 first", 32'hFEE5_5000, 32'h91);
    push("R8", 32'hFEE0_0004, 32'h92);
    expect_msg("R8 second", 32'hFEE5_5004 & 32'hFFF0_0FFF | 32'h000F_5000, 32'h92);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_passthru();
    t_arb();
    t_tie();
    t_window();
    t_order();
    t_ready();
    t_b2b();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule